// File: doc/BRIEF.md
# Memory-Mapped Region Access Gate

The gate sits between a simple memory-mapped request port and a bank of register regions. Each request carries an address, a size code, a write flag and write data. The gate subtracts a programmable base from the address, compares the resulting offset against a table of regions in parallel, and then checks the requested width and alignment against that region's permissions. An access that passes is forwarded in the same cycle as a strobe, together with the region number and the offset inside the region.

Any access that fails is absorbed without an error. This covers an offset that lands in no region, a width the region does not permit, a misaligned address, and the 2-byte size, which no region accepts. A failed read returns all-zero data. A failed write is dropped.

Every request gets a response on the following cycle. Data is little-endian: byte 0 is bits [7:0]. Only the low bytes covered by the access width are carried in either direction.

Top module: `mmio_region_gate`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, rsp_valid_o is 0 and rsp_rdata_o is 0.
- R2: The offset is req_addr_i minus base_i, computed modulo 2^AW. Region i is hit when start_i <= offset < start_i + len_i. On a legal access, reg_idx_o is i and reg_offset_o is the offset minus start_i. When regions overlap, the lowest index wins.
- R3: Size code 0 (1 byte) is legal only if the region's flag bit 0 is set. Any address alignment is allowed.
- R4: Size code 2 (4 bytes) is legal only if the region's flag bit 1 is set and req_addr_i[1:0] is 0.
- R5: Size code 3 (8 bytes) is legal only if the region's flag bit 2 is set and req_addr_i[2:0] is 0.
- R6: Size code 1 (2 bytes) is illegal for every region, so reg_strobe_o stays 0.
- R7: A read that is unmapped or illegal raises no strobe, and its response carries rsp_rdata_o equal to 0.
- R8: A write that is unmapped or illegal raises no strobe and still receives a response.
- R9: rsp_valid_o is 1 exactly in the cycle after each cycle in which req_valid_i is 1, and 0 otherwise.
- R10: On a legal access, reg_wdata_o equals req_wdata_i with every byte at or above the access width cleared. For a legal read, the response carries reg_rdata_i, sampled in the request cycle, masked in the same way.
- R11: reg_strobe_o is 0 whenever req_valid_i is 0. reg_write_o and reg_size_o follow req_write_i and req_size_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | AW | Base address of the block |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | 64 | Write data, little-endian |
| rsp_valid_o | output | 1 | Response, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data; zero for failed reads and for writes |
| reg_strobe_o | output | 1 | Legal access to the selected region |
| reg_write_o | output | 1 | Direction toward the region |
| reg_idx_o | output | IDXW | Selected region number |
| reg_offset_o | output | AW | Offset inside the region |
| reg_size_o | output | 2 | Size code toward the region |
| reg_wdata_o | output | 64 | Write data masked to the access width |
| reg_rdata_i | input | 64 | Region read data, same cycle as the strobe |

## Verification
Two functions can fall in the same cycle: the response to one request is presented while the next request is being decoded and possibly strobed. The vector walk provokes this by issuing requests back to back with no idle cycle between them, mixing legal and illegal accesses. While this happens, the region side keeps returning non-zero read data. Each response is judged against the request one cycle earlier: a failed read must show zeros even though the region data is non-zero, and a legal read must show the masked pattern for its own region, not for the neighbouring request.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int unsigned DW = 64;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } size_e;

  localparam int unsigned FLAG_B1 = 0;
  localparam int unsigned FLAG_B4 = 1;
  localparam int unsigned FLAG_B8 = 2;
  localparam int unsigned FLAG_W  = 3;
endpackage

// File: rtl/mrg_region_match.sv
module mrg_region_match #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NR   = 4,
  parameter int unsigned IDXW = 2,
  parameter logic [NR*AW-1:0] START = '0,
  parameter logic [NR*AW-1:0] LEN   = '0
) (
  input  logic [AW-1:0]   offset_i,
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o,
  output logic [AW-1:0]   local_o,
  output logic [NR-1:0]   hit_vec_o
);
  logic [AW-1:0] sel_start;

  // one comparator pair per region; end computed one bit wider
  for (genvar g = 0; g < NR; g++) begin : g_cmp
    logic [AW:0] lim;
    assign lim = {1'b0, START[g*AW +: AW]} + {1'b0, LEN[g*AW +: AW]};
    assign hit_vec_o[g] = (offset_i >= START[g*AW +: AW]) &&
                          ({1'b0, offset_i} < lim);
  end

  // descending scan so the lowest index is assigned last
  always_comb begin
    hit_o     = 1'b0;
    idx_o     = '0;
    sel_start = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) begin
        hit_o     = 1'b1;
        idx_o     = IDXW'(i);
        sel_start = START[i*AW +: AW];
      end
    end
  end

  assign local_o = offset_i - sel_start;
endmodule

// File: rtl/mrg_access_check.sv
module mrg_access_check
  import mrg_pkg::*;
#(
  parameter int unsigned NR   = 4,
  parameter int unsigned IDXW = 2,
  parameter logic [NR*FLAG_W-1:0] FLAGS = '0
) (
  input  logic            hit_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [1:0]      size_i,
  input  logic [2:0]      addr_lo_i,
  output logic            legal_o
);
  logic [FLAG_W-1:0] flag_sel;

  always_comb begin
    flag_sel = '0;
    for (int i = 0; i < NR; i++) begin
      if (idx_i == IDXW'(i)) flag_sel = FLAGS[i*FLAG_W +: FLAG_W];
    end
  end

  always_comb begin
    unique case (size_e'(size_i))
      SZ_B1:   legal_o = flag_sel[FLAG_B1];
      SZ_B4:   legal_o = flag_sel[FLAG_B4] && (addr_lo_i[1:0] == 2'b00);
      SZ_B8:   legal_o = flag_sel[FLAG_B8] && (addr_lo_i == 3'b000);
      default: legal_o = 1'b0;
    endcase
    legal_o = legal_o && hit_i;
  end
endmodule

// File: rtl/mrg_lane_mask.sv
module mrg_lane_mask
  import mrg_pkg::*;
(
  input  logic [1:0]    size_i,
  output logic [DW-1:0] mask_o
);
  always_comb begin
    unique case (size_e'(size_i))
      SZ_B1:   mask_o = {{(DW-8){1'b0}},  {8{1'b1}}};
      SZ_B2:   mask_o = {{(DW-16){1'b0}}, {16{1'b1}}};
      SZ_B4:   mask_o = {{(DW-32){1'b0}}, {32{1'b1}}};
      default: mask_o = {DW{1'b1}};
    endcase
  end
endmodule

// File: rtl/mmio_region_gate.sv
module mmio_region_gate
  import mrg_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned NR = 4,
  parameter logic [NR*AW-1:0] REGION_START =
    {16'h0400, 16'h0200, 16'h0100, 16'h0000},
  parameter logic [NR*AW-1:0] REGION_LEN =
    {16'h0040, 16'h0100, 16'h0080, 16'h0010},
  parameter logic [NR*FLAG_W-1:0] REGION_FLAGS =
    {3'b001, 3'b110, 3'b011, 3'b010},
  localparam int unsigned IDXW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   base_i,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [1:0]      req_size_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_rdata_o,
  output logic            reg_strobe_o,
  output logic            reg_write_o,
  output logic [IDXW-1:0] reg_idx_o,
  output logic [AW-1:0]   reg_offset_o,
  output logic [1:0]      reg_size_o,
  output logic [DW-1:0]   reg_wdata_o,
  input  logic [DW-1:0]   reg_rdata_i
);
  logic [AW-1:0] offset;
  logic          hit, legal;
  logic [NR-1:0] hit_vec;
  logic [DW-1:0] lane_mask;

  assign offset = req_addr_i - base_i;

  mrg_region_match #(
    .AW(AW), .NR(NR), .IDXW(IDXW),
    .START(REGION_START), .LEN(REGION_LEN)
  ) u_match (
    .offset_i (offset),
    .hit_o    (hit),
    .idx_o    (reg_idx_o),
    .local_o  (reg_offset_o),
    .hit_vec_o(hit_vec)
  );

  mrg_access_check #(
    .NR(NR), .IDXW(IDXW), .FLAGS(REGION_FLAGS)
  ) u_check (
    .hit_i    (hit),
    .idx_i    (reg_idx_o),
    .size_i   (req_size_i),
    .addr_lo_i(req_addr_i[2:0]),
    .legal_o  (legal)
  );

  mrg_lane_mask u_mask (
    .size_i(req_size_i),
    .mask_o(lane_mask)
  );

  assign reg_strobe_o = req_valid_i && legal;
  assign reg_write_o  = req_write_i;
  assign reg_size_o   = req_size_i;
  assign reg_wdata_o  = req_wdata_i & lane_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= (reg_strobe_o && !req_write_i) ? (reg_rdata_i & lane_mask) : '0;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R9
  AST_FAILED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !reg_strobe_o) |=> (rsp_rdata_o == '0)); // R7
  AST_HALF_WORD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == SZ_B2) |-> !reg_strobe_o); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_strobe_o && req_size_i == SZ_B4) |-> (req_addr_i[1:0] == 2'b00)); // R4
  AST_DWORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_strobe_o && req_size_i == SZ_B8) |-> (req_addr_i[2:0] == 3'b000)); // R5
  AST_STROBE_HAS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_strobe_o |-> (hit_vec != '0)); // R2
  AST_WRITE_NO_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> (rsp_rdata_o == '0)); // R8
endmodule

// File: tb/mmio_region_gate_tb.sv
`timescale 1ns/1ps
module mmio_region_gate_tb_top;
  localparam logic [63:0] PAT = 64'hF1E2D3C4B5A69788;
  localparam logic [63:0] WD  = 64'h8877665544332211;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] base = 16'h1000;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = WD;
  logic        rsp_valid, reg_strobe, reg_write;
  logic [63:0] rsp_rdata, reg_wdata, reg_rdata;
  logic [1:0]  reg_idx, reg_size;
  logic [15:0] reg_offset;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  // region side model: pattern tagged with the region number
  assign reg_rdata = PAT ^ {62'b0, reg_idx};

  mmio_region_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .reg_strobe_o(reg_strobe), .reg_write_o(reg_write), .reg_idx_o(reg_idx),
    .reg_offset_o(reg_offset), .reg_size_o(reg_size), .reg_wdata_o(reg_wdata),
    .reg_rdata_i(reg_rdata)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [1:0]  sz;
    logic        wr;
    logic        legal;
    logic [1:0]  idx;
    logic [15:0] off;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{16'h1004, 2'd2, 1'b0, 1'b1, 2'd0, 16'h0004, 8'd2},  // R2 word read r0
    '{16'h1006, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd4},  // R4 misaligned word
    '{16'h1003, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd3},  // R3 byte not allowed in r0
    '{16'h1101, 2'd0, 1'b0, 1'b1, 2'd1, 16'h0001, 8'd3},  // R3 odd byte in r1
    '{16'h1104, 2'd2, 1'b1, 1'b1, 2'd1, 16'h0004, 8'd4},  // R4 word write r1
    '{16'h1108, 2'd3, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd5},  // R5 r1 lacks 8B
    '{16'h1208, 2'd3, 1'b0, 1'b1, 2'd2, 16'h0008, 8'd5},  // R5 dword read r2
    '{16'h120C, 2'd3, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd5},  // R5 misaligned dword
    '{16'h1204, 2'd2, 1'b1, 1'b1, 2'd2, 16'h0004, 8'd4},  // R4 word write r2
    '{16'h1207, 2'd0, 1'b1, 1'b0, 2'd0, 16'h0000, 8'd8},  // R8 byte write r2 dropped
    '{16'h1102, 2'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd6},  // R6 half read
    '{16'h1100, 2'd1, 1'b1, 1'b0, 2'd0, 16'h0000, 8'd6},  // R6 half write
    '{16'h143F, 2'd0, 1'b0, 1'b1, 2'd3, 16'h003F, 8'd2},  // R2 last byte of r3
    '{16'h1440, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd7},  // R7 just past r3
    '{16'h1010, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd7},  // R7 just past r0
    '{16'h10FC, 2'd2, 1'b1, 1'b0, 2'd0, 16'h0000, 8'd8},  // R8 gap write
    '{16'h0FFC, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd2},  // R2 below base wraps
    '{16'h1100, 2'd2, 1'b0, 1'b1, 2'd1, 16'h0000, 8'd2}   // R2 first word of r1
  };

  function automatic logic [63:0] bmask(input logic [1:0] s);
    case (s)
      2'd0: return 64'h0000_0000_0000_00FF;
      2'd1: return 64'h0000_0000_0000_FFFF;
      2'd2: return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] a, input logic [1:0] s, input logic w);
    @(negedge clk);
    req_valid = v; req_addr = a; req_size = s; req_write = w;
    #1;
  endtask

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state even with a request present
    req_valid = 1'b1; req_addr = 16'h1004; req_size = 2'd2;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk(rsp_rdata == '0, "R1 rdata in reset", rsp_rdata, 64'd0);
    @(negedge clk); req_valid = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid after release", 64'(rsp_valid), 64'd0);

    // back-to-back vector walk
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      string t;
      logic [63:0] exp_rd;
      v = VECS[k];
      t = $sformatf("R%0d vec%0d", v.tag, k);
      drive(1'b1, v.addr, v.sz, v.wr);
      chk(reg_strobe == v.legal, {t, " strobe"}, 64'(reg_strobe), 64'(v.legal));
      if (v.legal) begin
        chk(reg_idx == v.idx, {t, " idx"}, 64'(reg_idx), 64'(v.idx));
        chk(reg_offset == v.off, {t, " offset"}, 64'(reg_offset), 64'(v.off));
        chk(reg_write == v.wr && reg_size == v.sz, {t, " R11 dir/size"},
            64'({reg_write, reg_size}), 64'({v.wr, v.sz}));
        chk(reg_wdata == (WD & bmask(v.sz)), {t, " R10 wdata"}, reg_wdata, WD & bmask(v.sz));
      end
      exp_rd = (v.legal && !v.wr) ? ((PAT ^ {62'b0, v.idx}) & bmask(v.sz)) : 64'd0;
      @(posedge clk); #1;
      chk(rsp_valid == 1'b1, {t, " R9 rsp_valid"}, 64'(rsp_valid), 64'd1);
      chk(rsp_rdata == exp_rd, {t, (v.legal ? " R10 rdata" : " R7 rdata")}, rsp_rdata, exp_rd);
    end

    // R11 / R9: idle cycle at a legal address
    drive(1'b0, 16'h1100, 2'd2, 1'b0);
    chk(reg_strobe == 1'b0, "R11 no strobe when idle", 64'(reg_strobe), 64'd0);
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R9 no response after idle", 64'(rsp_valid), 64'd0);
    chk(rsp_rdata == '0, "R9 idle rdata", rsp_rdata, 64'd0);

    // R2: moved base
    base = 16'h3000;
    drive(1'b1, 16'h3208, 2'd3, 1'b0);
    chk(reg_strobe && reg_idx == 2'd2 && reg_offset == 16'h0008, "R2 new base",
        64'({reg_strobe, reg_idx, reg_offset}), 64'({1'b1, 2'd2, 16'h0008}));
    @(posedge clk); #1;
    chk(rsp_rdata == (PAT ^ 64'd2), "R10 dword read full width", rsp_rdata, PAT ^ 64'd2);

    // R10: byte write strips upper lanes
    req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    drive(1'b1, 16'h3101, 2'd0, 1'b1);
    chk(reg_strobe && reg_wdata == 64'hFF, "R10 byte write lanes", reg_wdata, 64'hFF);
    // R3: byte into region 0 with same data is refused
    drive(1'b1, 16'h3000, 2'd0, 1'b1);
    chk(reg_strobe == 1'b0, "R3 byte write to word-only region", 64'(reg_strobe), 64'd0);
    @(posedge clk); #1;
    chk(rsp_valid == 1'b1 && rsp_rdata == '0, "R8 dropped write still answered",
        64'({rsp_valid, rsp_rdata[0]}), 64'd2);
    drive(1'b0, 16'h0000, 2'd0, 1'b0);
    @(posedge clk); #1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule